// File: doc/BRIEF.md
# Program and Data Memory Access Router

This block sits beside an 8051-class core and decides, for every memory request, which memory answers it. A code fetch or MOVC read goes either to the 8 KB on-chip flash or to the external bus. An internal data access goes to lower RAM, upper RAM or the special-function-register window. The choice for the upper half of the data space depends on how the address was formed: direct or through a register pointer. A programming or dump port into the flash is also routed here, so that the security options can stop it.

Two option bits add protection. With the read-lock option set, every dump or programming request is refused: no flash select is raised, and the read data is forced to 0xFF. With the table-read lock set, a MOVC issued while the core is running from external code is refused in the same way. Every refusal raises a one-cycle `blocked` pulse. The external-access pin is captured while reset is held and kept for the whole run, so a glitch on the pin cannot move code fetches between memories.

The router is a small state machine. Its state is the route granted to the request taken at the last clock edge. The states are `ST_IDLE` (no request), `ST_FLASH`, `ST_EXT`, `ST_LO`, `ST_HI`, `ST_SFR`, `ST_PROG` and `ST_BLOCK`. From any state, a clock edge moves the machine to the state that the highest-priority pending request selects, or to `ST_IDLE` when no request is pending. No state holds for more than one cycle unless a matching request is presented again. Every output is decoded from the state alone.

Top module: `mem_route_unit`

## Requirements
- R1: While `rst_n` is low, each clock edge captures `ea_pin` into the held external-access flag. After `rst_n` goes high, changes on `ea_pin` have no effect on routing.
- R2: A fetch (`code_req`=1, `code_movc`=0) at an address of 0x1FFF or below raises `sel_flash` when the held flag is 1, and raises `sel_ext_code` when the held flag is 0.
- R3: A fetch or MOVC at an address above 0x1FFF raises `sel_ext_code` and never `sel_flash`, whatever the held flag is.
- R4: A data access (`data_req`=1) to an address below 0x80 raises `sel_lo_ram`, for both `data_indirect`=1 and `data_indirect`=0.
- R5: A data access to an address of 0x80 or above raises `sel_hi_ram` when `data_indirect`=1, and raises `sel_sfr` when `data_indirect`=0.
- R6: A programming or dump request (`prog_req`=1) raises `sel_prog` when `opt_lock`=0. When `opt_lock`=1 it raises only `blocked`, and `rdata` reads 0xFF.
- R7: The core counts as running from external code when its most recent non-MOVC fetch was routed external. This flag is 0 after reset. While the flag is 1 and `opt_movc_lock`=1, a MOVC (`code_req`=1, `code_movc`=1) raises only `blocked`, and `rdata` reads 0xFF.
- R8: A MOVC that is not blocked is routed exactly like a fetch to the same address. A MOVC never changes the running-from-external flag.
- R9: Outputs appear in the cycle after the edge that samples the request. A request yields exactly one of the six selects or `blocked`. A cycle with no request yields none of them.
- R10: When several requests arrive in the same cycle, the code request is served first, then the data request, then the programming request. The requests that lose are dropped.
- R11: `rdata` equals 0xFF while `blocked` is high, and equals `flash_rdata` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ea_pin | input | 1 | External-access pin; low sends all code fetches to the external bus |
| code_req | input | 1 | Code-space request strobe |
| code_movc | input | 1 | 1 marks the code request as a MOVC table read |
| code_addr | input | 16 | Program counter or MOVC address |
| data_req | input | 1 | Internal data access strobe |
| data_indirect | input | 1 | 1 for register-pointer addressing, 0 for direct |
| data_addr | input | 8 | Internal data address |
| prog_req | input | 1 | Flash dump or programming request |
| opt_lock | input | 1 | Read-lock security option |
| opt_movc_lock | input | 1 | Table-read lock from external code |
| flash_rdata | input | 8 | Read data returned by the flash |
| sel_flash | output | 1 | Code request routed to internal flash |
| sel_ext_code | output | 1 | Code request routed to the external bus |
| sel_lo_ram | output | 1 | Data access routed to lower RAM |
| sel_hi_ram | output | 1 | Data access routed to upper RAM |
| sel_sfr | output | 1 | Data access routed to the register window |
| sel_prog | output | 1 | Programming or dump request granted to the flash |
| blocked | output | 1 | One-cycle refusal pulse |
| rdata | output | 8 | Read data, replaced by 0xFF on refusal |

## Verification
Assertions in the RTL check several rules on every cycle:
- the held external-access flag stays constant outside reset;
- an address above the flash never raises the flash select;
- a request is followed by exactly one grant, and an idle cycle by none;
- the refusal data is 0xFF;
- a direct upper-half access lands in the register window.

Some behaviours only show up in the bench's scenarios, which compare every cycle against a behavioural model:
- capture of the pin during a second reset;
- the running-from-external history that decides MOVC blocking;
- the priority order among simultaneous requests;
- pass-through of flash data once the lock is cleared.

// File: rtl/mru_pkg.sv
package mru_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FLASH = 3'd1,
        ST_EXT   = 3'd2,
        ST_LO    = 3'd3,
        ST_HI    = 3'd4,
        ST_SFR   = 3'd5,
        ST_PROG  = 3'd6,
        ST_BLOCK = 3'd7
    } route_t;
endpackage

// File: rtl/mru_code_path.sv
module mru_code_path
    import mru_pkg::*;
#(
    parameter int CODE_AW     = 16,
    parameter int FLASH_BYTES = 8192
) (
    input  logic [CODE_AW-1:0] addr,
    input  logic               is_movc,
    input  logic               ea_held,
    input  logic               run_ext,
    input  logic               movc_lock,
    output route_t             route,
    output logic               run_ext_next
);
    localparam logic [CODE_AW-1:0] FLASH_TOP = CODE_AW'(FLASH_BYTES - 1);

    logic to_ext;

    always_comb begin
        to_ext = !ea_held || (addr > FLASH_TOP);
        if (is_movc && movc_lock && run_ext)
            route = ST_BLOCK;
        else if (to_ext)
            route = ST_EXT;
        else
            route = ST_FLASH;
        run_ext_next = is_movc ? run_ext : to_ext;
    end
endmodule

// File: rtl/mru_data_path.sv
module mru_data_path
    import mru_pkg::*;
#(
    parameter int DATA_AW   = 8,
    parameter int LOW_BYTES = 128
) (
    input  logic [DATA_AW-1:0] addr,
    input  logic               indirect,
    output route_t             route
);
    localparam logic [DATA_AW-1:0] LOW_LIMIT = DATA_AW'(LOW_BYTES);

    always_comb begin
        if (addr < LOW_LIMIT)
            route = ST_LO;
        else if (indirect)
            route = ST_HI;
        else
            route = ST_SFR;
    end
endmodule

// File: rtl/mru_prog_gate.sv
module mru_prog_gate
    import mru_pkg::*;
(
    input  logic   lock,
    output route_t route
);
    always_comb route = lock ? ST_BLOCK : ST_PROG;
endmodule

// File: rtl/mem_route_unit.sv
module mem_route_unit
    import mru_pkg::*;
#(
    parameter int CODE_AW     = 16,
    parameter int FLASH_BYTES = 8192,
    parameter int DATA_AW     = 8,
    parameter int LOW_BYTES   = 128,
    parameter int DW          = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ea_pin,
    input  logic               code_req,
    input  logic               code_movc,
    input  logic [CODE_AW-1:0] code_addr,
    input  logic               data_req,
    input  logic               data_indirect,
    input  logic [DATA_AW-1:0] data_addr,
    input  logic               prog_req,
    input  logic               opt_lock,
    input  logic               opt_movc_lock,
    input  logic [DW-1:0]      flash_rdata,
    output logic               sel_flash,
    output logic               sel_ext_code,
    output logic               sel_lo_ram,
    output logic               sel_hi_ram,
    output logic               sel_sfr,
    output logic               sel_prog,
    output logic               blocked,
    output logic [DW-1:0]      rdata
);
    localparam logic [CODE_AW-1:0] FLASH_TOP = CODE_AW'(FLASH_BYTES - 1);
    localparam logic [DATA_AW-1:0] LOW_LIMIT = DATA_AW'(LOW_BYTES);
    localparam logic [DW-1:0]      FILL      = '1;

    route_t state, state_nx, code_rt, data_rt, prog_rt;
    logic   ea_held, run_ext, run_ext_nx;

    mru_code_path #(.CODE_AW(CODE_AW), .FLASH_BYTES(FLASH_BYTES)) u_code (
        .addr(code_addr), .is_movc(code_movc), .ea_held(ea_held),
        .run_ext(run_ext), .movc_lock(opt_movc_lock),
        .route(code_rt), .run_ext_next(run_ext_nx)
    );

    mru_data_path #(.DATA_AW(DATA_AW), .LOW_BYTES(LOW_BYTES)) u_data (
        .addr(data_addr), .indirect(data_indirect), .route(data_rt)
    );

    mru_prog_gate u_prog (.lock(opt_lock), .route(prog_rt));

    // Next state: code beats data beats programming
    always_comb begin
        if (code_req)
            state_nx = code_rt;
        else if (data_req)
            state_nx = data_rt;
        else if (prog_req)
            state_nx = prog_rt;
        else
            state_nx = ST_IDLE;
    end

    // State register and held context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            ea_held <= ea_pin;
            run_ext <= 1'b0;
        end else begin
            state <= state_nx;
            if (code_req)
                run_ext <= run_ext_nx;
        end
    end

    // Output decode
    always_comb begin
        sel_flash    = 1'b0;
        sel_ext_code = 1'b0;
        sel_lo_ram   = 1'b0;
        sel_hi_ram   = 1'b0;
        sel_sfr      = 1'b0;
        sel_prog     = 1'b0;
        blocked      = 1'b0;
        rdata        = flash_rdata;
        unique case (state)
            ST_IDLE:  ;
            ST_FLASH: sel_flash    = 1'b1;
            ST_EXT:   sel_ext_code = 1'b1;
            ST_LO:    sel_lo_ram   = 1'b1;
            ST_HI:    sel_hi_ram   = 1'b1;
            ST_SFR:   sel_sfr      = 1'b1;
            ST_PROG:  sel_prog     = 1'b1;
            ST_BLOCK: begin
                blocked = 1'b1;
                rdata   = FILL;
            end
        endcase
    end

    // R1
    ea_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(ea_held));

    // R3
    high_code_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_req && code_addr > FLASH_TOP) |=> !sel_flash);

    // R9
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_req || data_req || prog_req) |=>
        $countones({sel_flash, sel_ext_code, sel_lo_ram, sel_hi_ram,
                    sel_sfr, sel_prog, blocked}) == 1);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(code_req || data_req || prog_req) |=>
        !(sel_flash || sel_ext_code || sel_lo_ram || sel_hi_ram ||
          sel_sfr || sel_prog || blocked));

    // R11
    fill_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |-> rdata == FILL);

    // R5
    direct_sfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!code_req && data_req && !data_indirect && data_addr >= LOW_LIMIT)
        |=> sel_sfr);
endmodule

// File: tb/tb_mem_route_unit.sv
module tb_mem_route_unit;
    logic clk = 0;
    logic rst_n = 0;
    logic ea_pin = 1;
    logic code_req = 0, code_movc = 0;
    logic [15:0] code_addr = '0;
    logic data_req = 0, data_indirect = 0;
    logic [7:0] data_addr = '0;
    logic prog_req = 0, opt_lock = 0, opt_movc_lock = 0;
    logic [7:0] flash_rdata = 8'h5A;
    logic sel_flash, sel_ext_code, sel_lo_ram, sel_hi_ram, sel_sfr, sel_prog, blocked;
    logic [7:0] rdata;

    int checks = 0, errors = 0;
    int m_ea = 1, m_ext = 0;

    always #2 clk = ~clk;

    mem_route_unit dut (
        .clk(clk), .rst_n(rst_n), .ea_pin(ea_pin),
        .code_req(code_req), .code_movc(code_movc), .code_addr(code_addr),
        .data_req(data_req), .data_indirect(data_indirect), .data_addr(data_addr),
        .prog_req(prog_req), .opt_lock(opt_lock), .opt_movc_lock(opt_movc_lock),
        .flash_rdata(flash_rdata),
        .sel_flash(sel_flash), .sel_ext_code(sel_ext_code), .sel_lo_ram(sel_lo_ram),
        .sel_hi_ram(sel_hi_ram), .sel_sfr(sel_sfr), .sel_prog(sel_prog),
        .blocked(blocked), .rdata(rdata)
    );

    // grant codes: 0 none 1 flash 2 ext 3 lo 4 hi 5 sfr 6 prog 7 block
    function automatic logic [6:0] grant_vec(int g);
        logic [6:0] v = '0;
        if (g > 0) v[g-1] = 1'b1;
        return v;
    endfunction

    task automatic compare(int g, string tag);
        logic [6:0] act, exp;
        logic [7:0] exp_d;
        act = {blocked, sel_prog, sel_sfr, sel_hi_ram, sel_lo_ram, sel_ext_code, sel_flash};
        exp = grant_vec(g);
        exp_d = (g == 7) ? 8'hFF : flash_rdata;
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s grants act=%b exp=%b", tag, act, exp);
        end
        checks++;
        if (rdata !== exp_d) begin
            errors++;
            $display("FAIL R11/%s rdata act=%h exp=%h", tag, rdata, exp_d);
        end
    endtask

    // Drive one cycle at a negedge, predict, then check at the next negedge
    task automatic step(string tag);
        int g = 0;
        int far;
        if (code_req) begin
            far = (code_addr > 16'h1FFF);
            if (code_movc && opt_movc_lock && m_ext == 1) g = 7;
            else if (m_ea == 0 || far != 0) g = 2;
            else g = 1;
            if (!code_movc) m_ext = (m_ea == 0 || far != 0) ? 1 : 0;
        end else if (data_req) begin
            if (data_addr < 8'h80) g = 3;
            else g = data_indirect ? 4 : 5;
        end else if (prog_req) begin
            g = opt_lock ? 7 : 6;
        end
        @(negedge clk);
        code_req = 0; data_req = 0; prog_req = 0; code_movc = 0;
        compare(g, tag);
    endtask

    task automatic fetch(logic movc, logic [15:0] a, string tag);
        code_req = 1; code_movc = movc; code_addr = a;
        step(tag);
    endtask

    task automatic daccess(logic ind, logic [7:0] a, string tag);
        data_req = 1; data_indirect = ind; data_addr = a;
        step(tag);
    endtask

    task automatic do_reset(logic ea);
        rst_n = 0; ea_pin = ea;
        repeat (3) @(negedge clk);
        m_ea = ea; m_ext = 0;
        rst_n = 1;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog act=hung exp=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset(1'b1);
        compare(0, "R9_reset");
        step("R9_idle");
        // R2 flash window, boundary
        fetch(0, 16'h0000, "R2_low");
        fetch(0, 16'h1FFF, "R2_top");
        // R3 above flash
        fetch(0, 16'h2000, "R3_edge");
        fetch(0, 16'hFFFF, "R3_max");
        // R7 movc from external code, lock on
        opt_movc_lock = 1;
        flash_rdata = 8'h3C;
        fetch(1, 16'h0100, "R7_block");
        fetch(1, 16'h0101, "R7_again");
        // R8 movc does not change run flag; back to internal fetch clears it
        fetch(0, 16'h0010, "R2_back");
        fetch(1, 16'h0200, "R8_inside");
        fetch(1, 16'h3000, "R8_far");
        fetch(1, 16'h0201, "R8_noflag");
        opt_movc_lock = 0;
        fetch(0, 16'h4000, "R3_run");
        fetch(1, 16'h0050, "R8_unlocked");
        // R4 / R5 data space
        daccess(0, 8'h00, "R4_direct");
        daccess(1, 8'h7F, "R4_indirect");
        daccess(1, 8'h80, "R5_hi");
        daccess(0, 8'h80, "R5_sfr");
        daccess(1, 8'hFF, "R5_hi_top");
        daccess(0, 8'hFF, "R5_sfr_top");
        // R6 programming port
        flash_rdata = 8'hA7;
        prog_req = 1; step("R6_open");
        opt_lock = 1;
        prog_req = 1; step("R6_locked");
        prog_req = 1; step("R6_locked2");
        // R10 priority
        code_req = 1; code_addr = 16'h0001; data_req = 1; data_addr = 8'h10; prog_req = 1;
        step("R10_code");
        data_req = 1; data_indirect = 1; data_addr = 8'h90; prog_req = 1;
        step("R10_data");
        opt_lock = 0;
        step("R9_quiet");
        // R1 pin ignored after reset
        ea_pin = 0;
        fetch(0, 16'h0002, "R1_ignore");
        // R1 capture low on a second reset
        do_reset(1'b0);
        ea_pin = 1;
        fetch(0, 16'h0003, "R1_capture");
        fetch(0, 16'h1FFF, "R2_ea_low");
        opt_movc_lock = 1;
        fetch(1, 16'h0004, "R7_ea_low");
        opt_movc_lock = 0;
        for (int i = 0; i < 8; i++) begin
            daccess(i[0], 8'(i * 37), "R4_R5_sweep");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule